// File: doc/BRIEF.md
# Byte Nonvolatile Store Access Controller

This block connects the I/O register space of an 8-bit processor to a small byte-wide nonvolatile data store. The store is modelled here as a register array with 2^ADDR_W entries, which is 64 bytes by default. Software reaches the block through three registers: an address register, a data register and a control register. Every access moves exactly one byte. A read copies the addressed byte into the data register. A write programs the data register's byte into the store and then runs a long, self-timed busy period. A cycle counter stands in for the physical cell programming time, which would be several milliseconds in silicon.

Two protections guard against stray writes. First, a write strobe takes effect only if an arm bit was set a few cycles earlier. Second, while programming is under way the address and data registers are frozen and all further strobes are dropped. After every accepted access the block raises a stall request so the processor holds its next instruction: 2 cycles after a write and 4 cycles after a read. A ready interrupt, held as a level, tells software that the next byte may be written.

A generate option chooses when the array is updated: on the acceptance edge, or on the last edge of the busy period. The registers and ports look the same to software in both variants.

Top module: `nvbyte_ctrl`

## Requirements
- R1: Register select 0 is the address register, which holds ADDR_W bits (6 by default, upper read bits 0). Select 1 is the data register. Select 2 is control, with bit 0 = read strobe (reads 0), bit 1 = write strobe / busy, bit 2 = arm, bit 3 = ready-interrupt enable. Select 3 reads 0. Register reads are combinational.
- R2: Writing 1 to control bit 2 while idle sets the arm bit, which then reads 1. The arm bit clears itself after ARM_WIN (4) cycles. Writing 0 to bit 2 has no effect.
- R3: A write strobe is accepted only on an edge where the arm bit already reads 1. Otherwise it is ignored: busy stays 0 and the stored byte is unchanged. An accepted write clears the arm bit.
- R4: An accepted write stores the data register at the address register. Control bit 1 reads 1 for exactly PROG_CYCLES cycles starting in the cycle after acceptance, then reads 0.
- R5: The stall output is high for exactly 2 cycles after a write is accepted.
- R6: A read strobe while idle holds stall high for exactly 4 cycles. When stall falls, the data register holds the addressed byte.
- R7: While busy, read strobes, write strobes and arm requests are ignored. While busy or stalled, writes to the address and data registers are ignored.
- R8: irq is a level equal to (enable bit 3 AND not busy). The enable bit is writable at any time, and clearing it removes irq.
- R9: Reset clears the control register, stall and irq, and leaves the array contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wr | input | 1 | Register write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| stall | output | 1 | Processor stall request |
| irq | output | 1 | Ready interrupt level |

## Verification
A wrong busy counter shows at control bit 1. The bit reads 1 for too few or too many cycles, and the error appears within PROG_CYCLES cycles of the write. A fault in the arm window appears at the next strobe. A strobe on the fourth cycle after arming must start a write, and a strobe on the fifth must not; either mistake shows up at once as busy or stall. A wrong stall count or a late read load is visible the cycle stall falls, through the stall width and the data register contents. A broken register lock shows as soon as the address or data register is read back during busy.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } nvb_sel_e;

   localparam int CB_RD  = 0;
   localparam int CB_WR  = 1;
   localparam int CB_ARM = 2;
   localparam int CB_IE  = 3;

   localparam int CTRL_BITS = 4;

endpackage

// File: rtl/nvb_down_timer.sv
module nvb_down_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);

   if (CNT_W < 1) begin : g_bad_w
      $error("nvb_down_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (count != '0) begin
         count <= count - CNT_W'(1);
      end
   end

endmodule

// File: rtl/nvb_byte_array.sv
module nvb_byte_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][DATA_W-1:0] cells_flat;

   // One register per entry; no reset so contents survive rst_n.
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (we && (waddr == ADDR_W'(i))) begin
            cell_q <= wdata;
         end
      end
      assign cells_flat[i] = cell_q;
   end

   assign rdata = cells_flat[raddr];

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
   import nvb_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int PROG_CYCLES = 40,
   parameter int ARM_WIN     = 4,
   parameter int WR_STALL    = 2,
   parameter int RD_STALL    = 4,
   parameter bit COMMIT_LATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              stall,
   output logic              irq
);

   localparam int STALL_MAX = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
   localparam int SW        = $clog2(STALL_MAX + 1);
   localparam int PW        = $clog2(PROG_CYCLES + 1);
   localparam int AW        = $clog2(ARM_WIN + 1);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 10 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("nvbyte_ctrl: ADDR_W must be 1..10 and not wider than DATA_W");
   end
   if (DATA_W < CTRL_BITS) begin : g_bad_data
      $error("nvbyte_ctrl: DATA_W too narrow for the control register");
   end
   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("nvbyte_ctrl: PROG_CYCLES must be at least 2");
   end
   if (ARM_WIN < 1 || WR_STALL < 1 || RD_STALL < 1) begin : g_bad_win
      $error("nvbyte_ctrl: ARM_WIN, WR_STALL and RD_STALL must be positive");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              ie_q;
   logic [AW-1:0]     arm_cnt;
   logic [SW-1:0]     stall_cnt;
   logic [PW-1:0]     prog_cnt;
   logic              arm;
   logic              busy;
   logic              idle;
   logic              ctrl_wr;
   logic              wr_acc;
   logic              rd_acc;
   logic              arm_set;
   logic              arr_we;
   logic [DATA_W-1:0] arr_rdata;
   logic [DATA_W-1:0] ctrl_view;

   assign arm   = (arm_cnt != '0);
   assign busy  = (prog_cnt != '0);
   assign stall = (stall_cnt != '0);
   assign idle  = !busy && !stall;

   // Control register decode
   assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
   assign wr_acc  = ctrl_wr && reg_wdata[CB_WR] && arm && idle;
   assign rd_acc  = ctrl_wr && reg_wdata[CB_RD] && idle && !wr_acc;
   assign arm_set = ctrl_wr && reg_wdata[CB_ARM] && idle && !wr_acc;

   // Arm window: reload on request, cleared by an accepted write
   nvb_down_timer #(.CNT_W(AW)) u_arm_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (arm_set),
      .load_val (AW'(ARM_WIN)),
      .clr      (wr_acc),
      .count    (arm_cnt)
   );

   // Processor stall length depends on the access kind
   nvb_down_timer #(.CNT_W(SW)) u_stall_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_acc || rd_acc),
      .load_val (wr_acc ? SW'(WR_STALL) : SW'(RD_STALL)),
      .clr      (1'b0),
      .count    (stall_cnt)
   );

   // Self-timed programming period
   nvb_down_timer #(.CNT_W(PW)) u_prog_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_acc),
      .load_val (PW'(PROG_CYCLES)),
      .clr      (1'b0),
      .count    (prog_cnt)
   );

   // Array update point: acceptance edge or final busy edge
   if (COMMIT_LATE) begin : g_commit_late
      assign arr_we = (prog_cnt == PW'(1));
   end else begin : g_commit_early
      assign arr_we = wr_acc;
   end

   nvb_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .we    (arr_we),
      .waddr (addr_q),
      .wdata (data_q),
      .raddr (addr_q),
      .rdata (arr_rdata)
   );

   // Address register: locked while busy or stalled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (reg_wr && (reg_sel == SEL_ADDR) && idle) begin
         addr_q <= reg_wdata[ADDR_W-1:0];
      end
   end

   // Data register: software write when idle, array copy on read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_acc) begin
         data_q <= arr_rdata;
      end else if (reg_wr && (reg_sel == SEL_DATA) && idle) begin
         data_q <= reg_wdata;
      end
   end

   // Interrupt enable is writable at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else if (ctrl_wr) begin
         ie_q <= reg_wdata[CB_IE];
      end
   end

   always_comb begin
      ctrl_view         = '0;
      ctrl_view[CB_WR]  = busy;
      ctrl_view[CB_ARM] = arm;
      ctrl_view[CB_IE]  = ie_q;
   end

   always_comb begin
      unique case (reg_sel)
         SEL_ADDR: reg_rdata = DATA_W'(addr_q);
         SEL_DATA: reg_rdata = data_q;
         SEL_CTRL: reg_rdata = ctrl_view;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = ie_q && !busy;

endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int PROG_CYCLES = 40,
   parameter int ARM_WIN     = 4,
   parameter int WR_STALL    = 2,
   parameter int RD_STALL    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_sel,
   input logic              reg_wr,
   input logic [3:0]        ctl_bits,
   input logic              stall,
   input logic              irq,
   input logic              busy,
   input logic              arm,
   input logic              ie_q,
   input logic [ADDR_W-1:0] addr_q,
   input logic [DATA_W-1:0] data_q
);

   logic        ctrl_wr_c;
   logic        wr_acc_c;
   logic        rd_acc_c;
   logic        arm_set_c;
   logic        last_wr;
   int unsigned stall_run;
   int unsigned busy_run;
   int unsigned arm_run;

   assign ctrl_wr_c = reg_wr && (reg_sel == 2'd2);
   assign wr_acc_c  = ctrl_wr_c && ctl_bits[1] && arm && !busy && !stall;
   assign rd_acc_c  = ctrl_wr_c && ctl_bits[0] && !busy && !stall && !wr_acc_c;
   assign arm_set_c = ctrl_wr_c && ctl_bits[2] && !busy && !stall && !wr_acc_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_run <= 0;
         busy_run  <= 0;
         arm_run   <= 0;
         last_wr   <= 1'b0;
      end else begin
         stall_run <= stall ? stall_run + 1 : 0;
         busy_run  <= busy ? busy_run + 1 : 0;
         if (arm_set_c)   arm_run <= 1;
         else if (arm)    arm_run <= arm_run + 1;
         else             arm_run <= 0;
         if (wr_acc_c)      last_wr <= 1'b1;
         else if (rd_acc_c) last_wr <= 1'b0;
      end
   end

   assert_arm_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> (arm_run >= 1 && arm_run <= ARM_WIN));

   assert_no_unarmed_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_c && ctl_bits[1] && !arm && !busy && !stall) |=> !busy);

   assert_wr_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc_c |=> (busy && stall && !arm));

   assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == PROG_CYCLES));

   assert_wr_stall_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stall) && last_wr) |-> (stall_run == WR_STALL));

   assert_rd_stall_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stall) && !last_wr) |-> (stall_run == RD_STALL));

   assert_rd_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc_c |=> (stall && !busy));

   assert_addr_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || stall) |=> $stable(addr_q));

   assert_data_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(data_q));

   assert_irq_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !irq);

   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (ie_q && !busy));

endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .PROG_CYCLES (PROG_CYCLES),
   .ARM_WIN     (ARM_WIN),
   .WR_STALL    (WR_STALL),
   .RD_STALL    (RD_STALL)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_sel  (reg_sel),
   .reg_wr   (reg_wr),
   .ctl_bits (reg_wdata[3:0]),
   .stall    (stall),
   .irq      (irq),
   .busy     (busy),
   .arm      (arm),
   .ie_q     (ie_q),
   .addr_q   (addr_q),
   .data_q   (data_q)
);

// File: tb/nvbyte_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvbyte_ctrl_tb_top;

   localparam int PROG = 40;
   localparam logic [1:0] S_A = 2'd0;
   localparam logic [1:0] S_D = 2'd1;
   localparam logic [1:0] S_C = 2'd2;
   localparam logic [7:0] B_RD  = 8'h01;
   localparam logic [7:0] B_WR  = 8'h02;
   localparam logic [7:0] B_ARM = 8'h04;
   localparam logic [7:0] B_IE  = 8'h08;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       stall;
   logic       irq;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic ie_on = 1'b0;
   logic [7:0] model [64];
   logic [5:0] wlist [32];
   int nw = 0;

   always #2.5 clk = ~clk;

   nvbyte_ctrl #(.PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stall(stall), .irq(irq));

   function automatic logic [7:0] ie_bits();
      return ie_on ? B_IE : 8'h00;
   endfunction

   function automatic logic [7:0] exp_ctrl(input logic ie, input logic armb, input logic bsy);
      return {4'h0, ie, armb, bsy, 1'b0};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk);
      reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_idle(output int cb, output int cs, output bit irq_seen);
      logic [7:0] v;
      cb = 0; cs = 0; irq_seen = 0;
      for (int k = 0; k < 1000; k++) begin
         rd_reg(S_C, v);
         if (!v[1]) break;
         cb++;
         if (stall) cs++;
         if (irq) irq_seen = 1;
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic [5:0] a, input logic [7:0] d, input int gap);
      int cb, cs; bit iq;
      wr_reg(S_A, {2'b00, a});
      wr_reg(S_D, d);
      wr_reg(S_C, B_ARM | ie_bits());
      repeat (gap) @(negedge clk);
      wr_reg(S_C, B_WR | ie_bits());
      wait_idle(cb, cs, iq);
      check(cb == PROG, "R4 busy length", cb, PROG);
      check(cs == 2, "R5 write stall length", cs, 2);
      check(!iq, "R8 irq low while busy", int'(iq), 0);
      model[a] = d;
   endtask

   task automatic do_read(input logic [5:0] a, input string req);
      int cs; logic [7:0] v;
      wr_reg(S_A, {2'b00, a});
      wr_reg(S_C, B_RD | ie_bits());
      cs = 0;
      while (stall && cs < 100) begin
         cs++;
         @(negedge clk);
      end
      check(cs == 4, "R6 read stall length", cs, 4);
      rd_reg(S_D, v);
      check(v == model[a], req, int'(v), int'(model[a]));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] oldv;
      int cb, cs; bit iq;
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd2718);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      rd_reg(S_C, v);
      check(v == 8'h00, "R9 control after reset", int'(v), 0);
      check(!stall && !irq, "R9 stall/irq after reset", int'({stall, irq}), 0);

      // R1 address width and data readback
      wr_reg(S_A, 8'hFF);
      rd_reg(S_A, v);
      check(v == 8'h3F, "R1 address register width", int'(v), 8'h3F);
      wr_reg(S_D, 8'hC3);
      rd_reg(S_D, v);
      check(v == 8'hC3, "R1 data register", int'(v), 8'hC3);
      rd_reg(2'd3, v);
      check(v == 8'h00, "R1 unused select", int'(v), 0);

      // R8 enable interrupt while idle
      ie_on = 1'b1;
      wr_reg(S_C, B_IE);
      check(irq == 1'b1, "R8 irq when ready and enabled", int'(irq), 1);

      // Random writes
      for (int i = 0; i < 10; i++) begin
         logic [5:0] a; logic [7:0] d;
         a = 6'($urandom_range(63));
         d = 8'($urandom);
         do_write(a, d, 0);
         wlist[nw] = a; nw++;
      end
      // Random reads of written locations
      for (int i = 0; i < 10; i++) begin
         do_read(wlist[$urandom_range(nw - 1)], "R6 read data");
      end

      // R2 arm visible, then clear by itself; late strobe ignored
      wr_reg(S_C, B_ARM | ie_bits());
      rd_reg(S_C, v);
      check(v == exp_ctrl(ie_on, 1'b1, 1'b0), "R2 arm reads 1", int'(v), int'(exp_ctrl(ie_on, 1'b1, 1'b0)));
      repeat (3) @(negedge clk);
      wr_reg(S_C, B_WR | ie_bits());
      rd_reg(S_C, v);
      check(v == exp_ctrl(ie_on, 1'b0, 1'b0), "R2 strobe after window ignored", int'(v), int'(exp_ctrl(ie_on, 1'b0, 1'b0)));
      check(!stall, "R2 no stall after expired arm", int'(stall), 0);

      // R2 writing 0 to arm has no effect; R3 unarmed strobe ignored
      oldv = model[wlist[0]];
      wr_reg(S_A, {2'b00, wlist[0]});
      wr_reg(S_D, ~oldv);
      wr_reg(S_C, B_WR | ie_bits());
      rd_reg(S_C, v);
      check(v[1] == 1'b0 && !stall, "R3 unarmed strobe ignored", int'(v), int'(exp_ctrl(ie_on, 1'b0, 1'b0)));
      check(v[2] == 1'b0, "R2 arm stays clear", int'(v[2]), 0);
      do_read(wlist[0], "R3 array unchanged after unarmed strobe");

      // R3 strobe on the last valid cycle of the window is accepted
      do_write(6'h15, 8'h96, 2);
      do_read(6'h15, "R3 last-window write stored");

      // R7 lock during busy, R8 enable clearing
      wr_reg(S_A, 8'h2A);
      wr_reg(S_D, 8'h5C);
      wr_reg(S_C, B_ARM | ie_bits());
      wr_reg(S_C, B_WR | ie_bits());
      wr_reg(S_A, 8'h11);
      rd_reg(S_A, v);
      check(v == 8'h2A, "R7 address locked while busy", int'(v), 8'h2A);
      wr_reg(S_D, 8'hA3);
      rd_reg(S_D, v);
      check(v == 8'h5C, "R7 data locked while busy", int'(v), 8'h5C);
      wr_reg(S_C, B_RD | ie_bits());
      check(!stall, "R7 read strobe ignored while busy", int'(stall), 0);
      wr_reg(S_C, B_ARM | ie_bits());
      rd_reg(S_C, v);
      check(v[2] == 1'b0, "R7 arm ignored while busy", int'(v[2]), 0);
      ie_on = 1'b0;
      wr_reg(S_C, 8'h00);
      check(!irq, "R8 irq off after enable cleared", int'(irq), 0);
      wait_idle(cb, cs, iq);
      check(!irq, "R8 irq stays off when ready but disabled", int'(irq), 0);
      ie_on = 1'b1;
      wr_reg(S_C, B_IE);
      check(irq, "R8 irq back on", int'(irq), 1);
      model[6'h2A] = 8'h5C;
      do_read(6'h2A, "R4 locked write stored");

      // R9 reset keeps array contents
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      ie_on = 1'b0;
      rd_reg(S_C, v);
      check(v == 8'h00, "R9 control after second reset", int'(v), 0);
      check(!irq, "R9 irq after second reset", int'(irq), 0);
      do_read(wlist[1], "R9 array preserved over reset");
      do_read(6'h15, "R9 array preserved over reset");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule